// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the register file for one DMA channel, as software sees it. Software uses it to set up a transfer: descriptor pointers, start address, two-dimensional counts and strides, and the peripheral assignment. Software then starts or stops the channel by writing the configuration register. The bank gives the channel engine single-cycle start, self-run and stop pulses. It records done and error events from the engine in a status register that software clears by writing ones. The bank does not move data, fetch descriptors or arbitrate for the bus.

Every register is read through the same slave port, either as a 16-bit access or as a 32-bit access. While the channel runs, most setup registers are protected against writes. The channel-type bit of the peripheral map can never be changed by software. An access of an illegal size is flagged first. An access to an unused slot is flagged only when the size is legal. Read data, error flags and control pulses all leave the block through registers.

Top module: `dma_chan_regs`

## Requirements
- R1: Register slots sit on 4-byte steps. Bits [5:2] of the byte address select the slot: 0 next descriptor pointer (32 bit), 1 start address (32 bit), 2 configuration, 4 X count, 5 X stride, 6 Y count, 7 Y stride, 8 current descriptor pointer (32 bit), 9 current address (32 bit), 10 status, 11 peripheral map, 12 current X count, 14 current Y count. Slots not marked 32 bit hold 16 bits.
- R2: While the status run bit is set, writes to slots 0, 1, 4 to 9, 11, 12 and 14 are discarded and leave the stored value unchanged. Configuration and status stay writable.
- R3: Status bit 0 (done) and bit 1 (error) are cleared by writing a 1 to them and are set by the engine inputs `eng_done` and `eng_err`. A set wins over a clear in the same cycle. Bit 3 is the run flag and cannot be written. `eng_done` clears the run flag.
- R4: A write to the peripheral map keeps the stored type bit (bit TYPE_BIT, default 6) and takes every other bit from the written data.
- R5: A configuration write with the enable bit (bit 0) set does four things one cycle later. It sets run and raises `start_pulse` for one cycle. It copies the next descriptor pointer into the current descriptor pointer and the start address into the current address. It loads the current X and Y counts from the X and Y counts, turning a count of 0 into 16'hFFFF. A configuration write with enable clear drops run and raises `stop_pulse` for one cycle.
- R6: `go_pulse` comes with `start_pulse` only when the peripheral-map type bit is 0 or configuration bit 1 (write direction) is set in the written value.
- R7: A 16-bit access selects the low half of a slot when address bit 1 is 0 and the high half when it is 1. The high half of a 16-bit register reads as zero and ignores writes. A 32-bit read of a 16-bit register returns it zero-extended. A 32-bit write to it stores the low 16 bits.
- R8: `bus_size` 2'b01 means 16 bits and must have address bit 0 clear. 2'b10 means 32 bits and must have address bits [1:0] clear. Any other access raises `size_err` one cycle later, changes nothing and reads zero, and it never raises `slot_err`.
- R9: Slots 3, 13 and 15 read as zero and ignore writes. A legal-size access to them raises `slot_err` one cycle later.
- R10: Reset clears every register and output. The only exception is the peripheral map, which loads the parameter PMAP_RESET.
- R11: `bus_rdata` shows the read value one cycle after the read, taken from the state before that edge. The 16-bit result is in bits [15:0] with the upper half zero. Outside valid reads the value is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address within the channel window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 2 | Access size: 01 = 16 bit, 10 = 32 bit |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| size_err | output | 1 | Illegal-size or misaligned access pulse |
| slot_err | output | 1 | Reserved-slot access pulse |
| eng_done | input | 1 | Engine sets done and ends the run |
| eng_err | input | 1 | Engine sets error |
| start_pulse | output | 1 | Channel enabled, process descriptor |
| go_pulse | output | 1 | Channel may start moving data itself |
| stop_pulse | output | 1 | Channel disabled, cancel pending work |

## Verification
Every result is due exactly one clock edge after the access or engine pulse that causes it. This covers read data, both error flags and the start, go and stop pulses. Register contents change on that same edge, so a read issued in the following cycle shows the new value. The bench drives on the falling edge and samples on the next falling edge, after exactly one rising edge. A behavioural model updates on the same rising edge and computes its read value from its state before the update. Its outputs are compared with the design on every falling edge, so any latency of zero or two cycles shows up as a mismatch.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter logic [15:0] PMAP_RESET = 16'h0040,
  parameter int          TYPE_BIT   = 6,
  parameter int          EN_BIT     = 0,
  parameter int          DIR_BIT    = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_size,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        size_err,
  output logic        slot_err,
  input  logic        eng_done,
  input  logic        eng_err,
  output logic        start_pulse,
  output logic        go_pulse,
  output logic        stop_pulse
);
  localparam logic [3:0] S_NDP = 4'd0, S_SA = 4'd1, S_CFG = 4'd2, S_XC = 4'd4,
                         S_XM = 4'd5, S_YC = 4'd6, S_YM = 4'd7, S_CDP = 4'd8,
                         S_CA = 4'd9, S_IRQ = 4'd10, S_PMAP = 4'd11,
                         S_CXC = 4'd12, S_CYC = 4'd14;
  localparam logic [15:0] TYPE_MASK = 16'(1) << TYPE_BIT;

  logic [31:0] ndp_q, sa_q, cdp_q, ca_q, rd32;
  logic [15:0] cfg_q, xc_q, xm_q, yc_q, ym_q, pmap_q, cxc_q, cyc_q, irq_view, w16;
  logic        done_q, err_q, run_q;
  logic [3:0]  slot;
  logic        access, sz16, sz32, size_ok, rsvd, hit, wr_ok, wr_hi, wr16_ok;
  logic        free32, free16, cfg_wr, en_new, irq_wr;

  function automatic logic [31:0] merge32(input logic [31:0] old, input logic [31:0] wd,
                                          input logic full, input logic hi);
    if (full)    return wd;
    else if (hi) return {wd[15:0], old[15:0]};
    else         return {old[31:16], wd[15:0]};
  endfunction

  assign slot     = bus_addr[5:2];
  assign access   = bus_wr | bus_rd;
  assign sz16     = (bus_size == 2'b01) && !bus_addr[0];
  assign sz32     = (bus_size == 2'b10) && (bus_addr[1:0] == 2'b00);
  assign size_ok  = sz16 | sz32;
  assign rsvd     = (slot == 4'd3) || (slot == 4'd13) || (slot == 4'd15);
  assign hit      = size_ok && !rsvd;
  assign wr_ok    = bus_wr && hit;
  assign wr_hi    = sz16 && bus_addr[1];
  assign wr16_ok  = wr_ok && !wr_hi;
  assign free32   = wr_ok && !run_q;
  assign free16   = wr16_ok && !run_q;
  assign w16      = bus_wdata[15:0];
  assign cfg_wr   = wr16_ok && (slot == S_CFG);
  assign irq_wr   = wr16_ok && (slot == S_IRQ);
  assign en_new   = bus_wdata[EN_BIT];
  assign irq_view = {12'd0, run_q, 1'b0, err_q, done_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ndp_q <= '0;
      sa_q  <= '0;
      cdp_q <= '0;
      ca_q  <= '0;
    end else begin
      if (free32) begin
        case (slot)
          S_NDP:   ndp_q <= merge32(ndp_q, bus_wdata, sz32, wr_hi);
          S_SA:    sa_q  <= merge32(sa_q,  bus_wdata, sz32, wr_hi);
          S_CDP:   cdp_q <= merge32(cdp_q, bus_wdata, sz32, wr_hi);
          S_CA:    ca_q  <= merge32(ca_q,  bus_wdata, sz32, wr_hi);
          default: ;
        endcase
      end
      if (cfg_wr && en_new) begin
        cdp_q <= ndp_q;
        ca_q  <= sa_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xc_q   <= '0;
      xm_q   <= '0;
      yc_q   <= '0;
      ym_q   <= '0;
      cxc_q  <= '0;
      cyc_q  <= '0;
      pmap_q <= PMAP_RESET;
    end else begin
      if (free16) begin
        case (slot)
          S_XC:    xc_q   <= w16;
          S_XM:    xm_q   <= w16;
          S_YC:    yc_q   <= w16;
          S_YM:    ym_q   <= w16;
          S_CXC:   cxc_q  <= w16;
          S_CYC:   cyc_q  <= w16;
          S_PMAP:  pmap_q <= (pmap_q & TYPE_MASK) | (w16 & ~TYPE_MASK);
          default: ;
        endcase
      end
      if (cfg_wr && en_new) begin
        cxc_q <= (xc_q == 16'd0) ? 16'hFFFF : xc_q;
        cyc_q <= (yc_q == 16'd0) ? 16'hFFFF : yc_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q       <= '0;
      run_q       <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      start_pulse <= 1'b0;
      go_pulse    <= 1'b0;
      stop_pulse  <= 1'b0;
    end else begin
      if (cfg_wr) cfg_q <= w16;
      if (cfg_wr)        run_q <= en_new;
      else if (eng_done) run_q <= 1'b0;
      if (eng_done)                    done_q <= 1'b1;
      else if (irq_wr && bus_wdata[0]) done_q <= 1'b0;
      if (eng_err)                     err_q <= 1'b1;
      else if (irq_wr && bus_wdata[1]) err_q <= 1'b0;
      start_pulse <= cfg_wr && en_new;
      go_pulse    <= cfg_wr && en_new && (!pmap_q[TYPE_BIT] || bus_wdata[DIR_BIT]);
      stop_pulse  <= cfg_wr && !en_new;
    end
  end

  always_comb begin
    case (slot)
      S_NDP:   rd32 = ndp_q;
      S_SA:    rd32 = sa_q;
      S_CFG:   rd32 = {16'd0, cfg_q};
      S_XC:    rd32 = {16'd0, xc_q};
      S_XM:    rd32 = {16'd0, xm_q};
      S_YC:    rd32 = {16'd0, yc_q};
      S_YM:    rd32 = {16'd0, ym_q};
      S_CDP:   rd32 = cdp_q;
      S_CA:    rd32 = ca_q;
      S_IRQ:   rd32 = {16'd0, irq_view};
      S_PMAP:  rd32 = {16'd0, pmap_q};
      S_CXC:   rd32 = {16'd0, cxc_q};
      S_CYC:   rd32 = {16'd0, cyc_q};
      default: rd32 = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      size_err  <= 1'b0;
      slot_err  <= 1'b0;
    end else begin
      if (!(bus_rd && hit)) bus_rdata <= '0;
      else if (sz32)        bus_rdata <= rd32;
      else                  bus_rdata <= {16'd0, wr_hi ? rd32[31:16] : rd32[15:0]};
      size_err <= access && !size_ok;
      slot_err <= access && size_ok && rsvd;
    end
  end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] bus_addr,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [1:0] bus_size,
  input logic       size_err,
  input logic       slot_err,
  input logic       eng_done,
  input logic       start_pulse,
  input logic       go_pulse,
  input logic       stop_pulse,
  input logic       run_q,
  input logic       done_q,
  input logic       pmap_type,
  input logic [15:0] xc_q
);
  logic legal;
  assign legal = ((bus_size == 2'b01) && !bus_addr[0]) ||
                 ((bus_size == 2'b10) && (bus_addr[1:0] == 2'b00));

  AST_SIZE_BEFORE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> !slot_err);                                            // R8
  AST_BAD_SIZE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && !legal) |=> size_err);                       // R8
  AST_XCOUNT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && bus_wr && bus_addr[5:2] == 4'd4) |=> $stable(xc_q));      // R2
  AST_TYPE_BIT_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(pmap_type));                                       // R4
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> done_q);                                               // R3
  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> run_q);                                             // R5
  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |-> !run_q);                                             // R5
  AST_NO_START_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_pulse && stop_pulse));                                      // R5
  AST_GO_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
    go_pulse |-> start_pulse);                                          // R6
endmodule

bind dma_chan_regs dma_chan_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_size(bus_size), .size_err(size_err), .slot_err(slot_err), .eng_done(eng_done),
  .start_pulse(start_pulse), .go_pulse(go_pulse), .stop_pulse(stop_pulse),
  .run_q(run_q), .done_q(done_q), .pmap_type(pmap_q[TYPE_BIT]), .xc_q(xc_q)
);

// File: tb/dma_chan_regs_tb_top.sv
module dma_chan_regs_tb_top;
  localparam logic [15:0] PMAP_A = 16'h0040;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, eng_done = 1'b0, eng_err = 1'b0;
  logic [1:0]  bus_size = 2'b00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, rdata_b;
  logic        size_err, slot_err, start_pulse, go_pulse, stop_pulse;
  logic        serr_b, lerr_b, start_b, go_b, stop_b;

  int tests = 0;
  int fails = 0;
  string cur = "R1";
  bit finished = 0;

  always #10 clk = ~clk;

  dma_chan_regs #(.PMAP_RESET(PMAP_A)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .size_err(size_err), .slot_err(slot_err), .eng_done(eng_done), .eng_err(eng_err),
    .start_pulse(start_pulse), .go_pulse(go_pulse), .stop_pulse(stop_pulse));

  dma_chan_regs #(.PMAP_RESET(16'h0000)) dut_b (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
    .size_err(serr_b), .slot_err(lerr_b), .eng_done(eng_done), .eng_err(eng_err),
    .start_pulse(start_b), .go_pulse(go_b), .stop_pulse(stop_b));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_reg [16];
  logic        m_run, m_done, m_err, m_serr, m_lerr, m_start, m_go, m_stop;
  logic [31:0] m_rdata, nv, rv;
  logic        new_run, m_hi, m_ok, m_rsv, m_is32;
  int          s;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_reg[i] = 32'd0;
      m_reg[11] = {16'd0, PMAP_A};
      {m_run, m_done, m_err, m_serr, m_lerr, m_start, m_go, m_stop} = '0;
      m_rdata = 32'd0;
    end else begin
      s      = int'(bus_addr[5:2]);
      m_ok   = (bus_size == 2'b01 && bus_addr[0] == 1'b0) || (bus_size == 2'b10 && bus_addr[1:0] == 2'b00);
      m_rsv  = (s == 3) || (s == 13) || (s == 15);
      m_hi   = (bus_size == 2'b01) && bus_addr[1];
      m_is32 = (s == 0) || (s == 1) || (s == 8) || (s == 9);
      m_serr = (bus_wr || bus_rd) && !m_ok;
      m_lerr = (bus_wr || bus_rd) && m_ok && m_rsv;
      m_start = 0; m_go = 0; m_stop = 0;
      new_run = m_run;
      rv = (s == 10) ? {28'd0, m_run, 1'b0, m_err, m_done} : (m_rsv ? 32'd0 : m_reg[s]);
      if (bus_rd && m_ok && !m_rsv)
        m_rdata = (bus_size == 2'b10) ? rv : {16'd0, m_hi ? rv[31:16] : rv[15:0]};
      else
        m_rdata = 32'd0;
      if (bus_wr && m_ok && !m_rsv && !(m_hi && !m_is32)) begin
        if (bus_size == 2'b10) nv = bus_wdata;
        else if (m_hi)         nv = {bus_wdata[15:0], m_reg[s][15:0]};
        else                   nv = {m_reg[s][31:16], bus_wdata[15:0]};
        if (!m_is32) nv = nv & 32'h0000FFFF;
        if (s == 2) begin
          m_reg[2] = nv;
          if (nv[0]) begin
            new_run = 1; m_start = 1;
            m_go = !m_reg[11][6] || nv[1];
            m_reg[8]  = m_reg[0];
            m_reg[9]  = m_reg[1];
            m_reg[12] = (m_reg[4] == 0) ? 32'hFFFF : m_reg[4];
            m_reg[14] = (m_reg[6] == 0) ? 32'hFFFF : m_reg[6];
          end else begin
            new_run = 0; m_stop = 1;
          end
        end else if (s == 10) begin
          if (nv[0]) m_done = 0;
          if (nv[1]) m_err = 0;
        end else if (s == 11) begin
          if (!m_run) m_reg[11] = (m_reg[11] & 32'h40) | (nv & 32'hFFBF);
        end else if (!m_run) begin
          m_reg[s] = nv;
        end
      end
      if (eng_done) begin
        m_done = 1;
        if (!m_start) new_run = 0;
      end
      if (eng_err) m_err = 1;
      m_run = new_run;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check({cur, " R11 rdata"}, bus_rdata, m_rdata);
      check({cur, " R8 size_err"}, {31'd0, size_err}, {31'd0, m_serr});
      check({cur, " R9 slot_err"}, {31'd0, slot_err}, {31'd0, m_lerr});
      check({cur, " R5 start"}, {31'd0, start_pulse}, {31'd0, m_start});
      check({cur, " R6 go"}, {31'd0, go_pulse}, {31'd0, m_go});
      check({cur, " R5 stop"}, {31'd0, stop_pulse}, {31'd0, m_stop});
    end
  end

  task automatic cyc(input logic w, input logic r, input logic [5:0] a, input logic [1:0] sz,
                     input logic [31:0] d, input logic dn, input logic er);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_size = sz; bus_wdata = d;
    eng_done = dn; eng_err = er;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; eng_done = 0; eng_err = 0; bus_wdata = '0;
  endtask

  task automatic wr32(input logic [5:0] a, input logic [31:0] d);
    cyc(1, 0, a, 2'b10, d, 0, 0);
  endtask
  task automatic wr16(input logic [5:0] a, input logic [15:0] d);
    cyc(1, 0, a, 2'b01, {16'd0, d}, 0, 0);
  endtask
  task automatic rd(input string tag, input logic [5:0] a, input logic [1:0] sz, input logic [31:0] exp);
    cur = tag;
    cyc(0, 1, a, sz, 32'd0, 0, 0);
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 start idle", {31'd0, start_pulse}, 32'd0);
    rd("R10 pmap reset", 6'h2C, 2'b10, 32'h0000_0040);
    rd("R10 cfg reset", 6'h08, 2'b10, 32'd0);
    rd("R10 status reset", 6'h28, 2'b01, 32'd0);

    cur = "R7";
    wr32(6'h00, 32'h1234_5678);
    rd("R7 ndp high half", 6'h02, 2'b01, 32'h0000_1234);
    rd("R7 ndp low half", 6'h00, 2'b01, 32'h0000_5678);
    wr16(6'h06, 16'hABCD);
    wr16(6'h04, 16'h0010);
    rd("R7 sa from halves", 6'h04, 2'b10, 32'hABCD_0010);
    wr32(6'h10, 32'hFFFF_0005);
    rd("R7 xcount zero-extended", 6'h10, 2'b10, 32'h0000_0005);
    wr16(6'h12, 16'h7777);
    rd("R7 high half of 16-bit reg", 6'h12, 2'b01, 32'd0);
    rd("R1 xcount still", 6'h10, 2'b01, 32'h0000_0005);
    wr16(6'h14, 16'h0004);
    rd("R1 xstride", 6'h14, 2'b10, 32'h0000_0004);

    cur = "R4";
    wr16(6'h2C, 16'hFFFF);
    rd("R4 pmap all ones", 6'h2C, 2'b01, 32'h0000_FFFF);
    wr16(6'h2C, 16'h0000);
    rd("R4 pmap keeps type", 6'h2C, 2'b01, 32'h0000_0040);
    wr16(6'h2C, 16'h0005);

    cur = "R9";
    cyc(1, 0, 6'h0C, 2'b10, 32'hDEAD_BEEF, 0, 0);
    check("R9 slot_err on write", {31'd0, slot_err}, 32'd1);
    rd("R9 reserved reads zero", 6'h0C, 2'b10, 32'd0);
    check("R9 slot_err on read", {31'd0, slot_err}, 32'd1);

    cur = "R8";
    cyc(0, 1, 6'h34, 2'b00, 32'd0, 0, 0);
    check("R8 size first", {30'd0, size_err, slot_err}, 32'h2);
    cyc(1, 0, 6'h01, 2'b10, 32'h5555_5555, 0, 0);
    check("R8 misaligned flag", {31'd0, size_err}, 32'd1);
    rd("R8 misaligned ignored", 6'h00, 2'b10, 32'h1234_5678);
    cyc(1, 0, 6'h10, 2'b11, 32'h0000_0099, 0, 0);
    rd("R8 bad size ignored", 6'h10, 2'b10, 32'h0000_0005);

    cur = "R5";
    cyc(1, 0, 6'h08, 2'b01, 32'h0000_0001, 0, 0);
    check("R5 start pulse", {31'd0, start_pulse}, 32'd1);
    check("R6 no go for type1 read", {31'd0, go_pulse}, 32'd0);
    check("R6 go for type0", {31'd0, go_b}, 32'd1);
    rd("R5 run set", 6'h28, 2'b01, 32'h0000_0008);
    rd("R5 cur x count", 6'h30, 2'b01, 32'h0000_0005);
    rd("R5 cur y count from zero", 6'h38, 2'b10, 32'h0000_FFFF);
    rd("R5 cur addr", 6'h24, 2'b10, 32'hABCD_0010);
    rd("R5 cur desc", 6'h20, 2'b10, 32'h1234_5678);

    cur = "R2";
    wr16(6'h10, 16'h0007);
    rd("R2 xcount locked", 6'h10, 2'b01, 32'h0000_0005);
    wr16(6'h2C, 16'h0000);
    rd("R2 pmap locked", 6'h2C, 2'b01, 32'h0000_0045);
    wr32(6'h24, 32'h0);
    rd("R2 cur addr locked", 6'h24, 2'b10, 32'hABCD_0010);

    cur = "R3";
    cyc(0, 0, 6'h00, 2'b00, 32'd0, 0, 1);
    rd("R3 err set", 6'h28, 2'b01, 32'h0000_000A);
    wr16(6'h28, 16'h000A);
    rd("R3 w1c err, run kept", 6'h28, 2'b01, 32'h0000_0008);
    cyc(0, 0, 6'h00, 2'b00, 32'd0, 1, 0);
    rd("R3 done ends run", 6'h28, 2'b10, 32'h0000_0001);
    cyc(1, 0, 6'h28, 2'b01, 32'h0000_0001, 1, 0);
    rd("R3 set wins over clear", 6'h28, 2'b01, 32'h0000_0001);
    wr16(6'h28, 16'h0001);
    rd("R3 done cleared", 6'h28, 2'b01, 32'd0);

    cur = "R2";
    wr16(6'h10, 16'h0007);
    rd("R2 xcount free when idle", 6'h10, 2'b01, 32'h0000_0007);

    cur = "R6";
    cyc(1, 0, 6'h08, 2'b10, 32'h0000_0003, 0, 0);
    check("R6 go with direction bit", {31'd0, go_pulse}, 32'd1);
    cur = "R5";
    cyc(1, 0, 6'h08, 2'b01, 32'h0000_0000, 0, 0);
    check("R5 stop pulse", {31'd0, stop_pulse}, 32'd1);
    rd("R5 run cleared", 6'h28, 2'b01, 32'd0);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule